// File: doc/BRIEF.md
# Block-Exact LMS Adaptive Filter

This block is an adaptive FIR filter that accepts a stream of input samples, each paired with a desired sample. For every pair it returns an error value. That error is bit-for-bit the value a plain sample-by-sample LMS filter would give. The filter works on blocks of four samples. While a block is being processed, the tap weights are frozen at their value from the start of the block. All four filter outputs for the block are formed against that one weight vector, and four parallel multiply-accumulate lanes do this work. This gives four preliminary errors.

The block then corrects the preliminary errors in order, by forward substitution through a unit lower-triangular system. The entries of that system are the step size times lag-1, lag-2 and lag-3 cross-correlations between recent input vectors. These correlations are kept up to date by a running recursion, so their cost does not depend on the tap count. The recursion is rebuilt by a direct sum over all taps at the start of every frame of `FRAME_LEN` samples. Once the four errors are exact, all four weight updates are folded into one pass over the taps.

The filter state (weights, correlations and errors) is held in `ACC_W`-bit two's complement and wraps modulo 2^ACC_W. The rearranged form uses only additions, subtractions and multiplications, so it matches sequential LMS in that ring exactly. Only the reported error is saturated to the sample width.

Top module: `block_exact_lms`

## Requirements
- R1: A sample pair is taken on each rising edge where `inValid` and `inReady` are both high. `inReady` is high while the four pairs of a block are gathered. It is low from the edge that takes the fourth pair until the edge that takes the block's fourth error. `inReady` and `outValid` are never high together.
- R2: With tap weights h_k and input history x, every error equals e[n] = d[n] − Σ_{k<TAPS} h_k·x[n−k]. After each sample the weights move by h_k += mu·e[n]·x[n−k]. All terms are signed, mu is unsigned, and all arithmetic is modulo 2^ACC_W.
- R3: `errOut` is e[n] clamped to the signed range of `DATA_W` bits: values above 2^(DATA_W−1)−1 give that maximum, and values below −2^(DATA_W−1) give that minimum.
- R4: `mu` is sampled when the first pair of a block is taken. That value is used for all four samples of the block. Changes to `mu` while the other three pairs are taken have no effect on the block.
- R5: After reset, all tap weights and the whole input history are zero, `inReady` is 1 and `outValid` is 0.
- R6: The four errors of a block appear in sample order. While `outValid` is high and `outReady` is low, `outValid` stays high and `errOut` does not change.
- R7: A block taken with `mu` = 0 leaves every tap weight unchanged, so later errors are those of the frozen filter.
- R8: Errors stay exact across frame boundaries. The correlation recursion restarts from a direct sum every `FRAME_LEN` samples.
- R9: `outValid` rises 2·TAPS+8 rising edges after the edge that takes a block's fourth pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input pair present |
| inReady | output | 1 | Block can take an input pair |
| xIn | input | DATA_W | Input sample, signed |
| dIn | input | DATA_W | Desired sample, signed |
| mu | input | MU_W | Step size, unsigned integer |
| outValid | output | 1 | Error value present |
| outReady | input | 1 | Consumer takes the error value |
| errOut | output | DATA_W | Saturated error, signed |

## Verification
The hardest case to reach from the ports is the correlation recursion after it has carried state across many blocks and across a frame restart. A wrong term there only shows once the weights are nonzero and the input history is long and varied. The stimulus runs several frames of full-range random samples with random step sizes. These quickly drive the weights into wrapping values, and every error is compared with a sequential LMS model of the same modulus. Directed blocks before that cover a zero step size, a step size that changes inside a block, a forced saturation after a mid-run reset, and random output backpressure.

// File: rtl/belms_pkg.sv
package belms_pkg;

  typedef enum logic [2:0] {
    ST_COLLECT,
    ST_FIR,
    ST_RECUR,
    ST_CORR,
    ST_UPD,
    ST_OUT
  } belms_state_e;

  typedef struct packed {
    logic       take;
    logic       startBlk;
    logic       frameInit;
    logic       firStep;
    logic       recurStep;
    logic       corrStep;
    logic       updStep;
    logic [1:0] lane;
  } belms_strobe_t;

endpackage

// File: rtl/belms_ctrl.sv
module belms_ctrl
  import belms_pkg::*;
#(
  parameter int TAPS      = 16,
  parameter int FRAME_LEN = 40
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic                  outReady,
  output logic                  outValid,
  output belms_strobe_t         stb,
  output logic [$clog2(TAPS):0] tapIdx
);
  localparam int CNT_W  = $clog2(TAPS) + 1;
  localparam int BLOCKS = FRAME_LEN / 4;
  localparam int BLK_W  = $clog2(BLOCKS) + 1;

  belms_state_e     state;
  logic [1:0]       lane;
  logic [CNT_W-1:0] cnt;
  logic [BLK_W-1:0] blkCnt;

  always_comb begin
    stb           = '0;
    stb.lane      = lane;
    stb.frameInit = (blkCnt == '0);
    inReady       = (state == ST_COLLECT);
    outValid      = (state == ST_OUT);
    unique case (state)
      ST_COLLECT: begin
        stb.take     = inValid;
        stb.startBlk = inValid && (lane == 2'd0);
      end
      ST_FIR:   stb.firStep   = 1'b1;
      ST_RECUR: stb.recurStep = 1'b1;
      ST_CORR:  stb.corrStep  = 1'b1;
      ST_UPD:   stb.updStep   = 1'b1;
      default: ;
    endcase
  end

  assign tapIdx = cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_COLLECT;
      lane   <= '0;
      cnt    <= '0;
      blkCnt <= '0;
    end else begin
      unique case (state)
        ST_COLLECT: if (inValid) begin
          lane <= lane + 2'd1;
          if (lane == 2'd3) begin
            state <= ST_FIR;
            cnt   <= '0;
          end
        end
        ST_FIR: begin
          if (cnt == CNT_W'(TAPS - 1)) begin
            state <= ST_RECUR;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_RECUR: begin
          lane <= lane + 2'd1;
          if (lane == 2'd3) state <= ST_CORR;
        end
        ST_CORR: begin
          lane <= lane + 2'd1;
          if (lane == 2'd3) begin
            state <= ST_UPD;
            cnt   <= '0;
          end
        end
        ST_UPD: begin
          if (cnt == CNT_W'(TAPS - 1)) begin
            state <= ST_OUT;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_OUT: if (outReady) begin
          lane <= lane + 2'd1;
          if (lane == 2'd3) begin
            state  <= ST_COLLECT;
            blkCnt <= (blkCnt == BLK_W'(BLOCKS - 1)) ? '0 : blkCnt + 1'b1;
          end
        end
        default: state <= ST_COLLECT;
      endcase
    end
  end

  // R1: taking the last error of a block reopens the input side
  a_r1_reopen_after_drain: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && lane == 2'd3) |=> inReady);

endmodule

// File: rtl/belms_datapath.sv
module belms_datapath
  import belms_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 48,
  parameter int MU_W   = 8,
  parameter int TAPS   = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  belms_strobe_t            stb,
  input  logic [$clog2(TAPS):0]    tapIdx,
  input  logic signed [DATA_W-1:0] xIn,
  input  logic signed [DATA_W-1:0] dIn,
  input  logic [MU_W-1:0]          muIn,
  output logic signed [DATA_W-1:0] errOut
);
  localparam int TI_W  = $clog2(TAPS);
  localparam int BUF_D = 2 ** $clog2(TAPS + 8);
  localparam int PTR_W = $clog2(BUF_D);
  localparam int MAXV  = 2 ** (DATA_W - 1) - 1;
  localparam int MINV  = -(2 ** (DATA_W - 1));

  typedef logic signed [ACC_W-1:0] acc_t;

  logic signed [DATA_W-1:0] xBuf [BUF_D];
  logic [PTR_W-1:0]         wp;
  acc_t dq [4];
  acc_t firAcc [4];
  acc_t errQ [4];
  acc_t coef [TAPS];
  acc_t corrR [3];
  acc_t lagTab [4][3];
  acc_t muA;

  acc_t firProd [4];
  acc_t initProd [3];
  acc_t corrNext [3];
  acc_t lagSum, errNext, updSum, coefNext;
  logic [TI_W-1:0] tapSel;

  // sample "off" positions back from the newest stored one plus one
  function automatic acc_t tapX(input int off);
    logic [PTR_W-1:0] idx;
    idx = wp - PTR_W'(off);
    return acc_t'(xBuf[idx]);
  endfunction

  function automatic logic signed [DATA_W-1:0] satW(input acc_t v);
    if (v > acc_t'(MAXV)) return DATA_W'(MAXV);
    if (v < acc_t'(MINV)) return DATA_W'(MINV);
    return DATA_W'(v);
  endfunction

  assign tapSel = tapIdx[TI_W-1:0];

  always_comb begin
    int k, j;
    k = int'(tapIdx);
    j = int'(stb.lane);
    for (int q = 0; q < 4; q++) firProd[q] = coef[tapSel] * tapX(4 - q + k);
    for (int p = 0; p < 3; p++) begin
      initProd[p] = tapX(5 + k) * tapX(6 + k + p);
      corrNext[p] = corrR[p] + tapX(4 - j) * tapX(5 - j + p)
                  - tapX(4 - j + TAPS) * tapX(5 - j + TAPS + p);
    end
    lagSum = '0;
    for (int i = 0; i < 3; i++)
      if (i < j) lagSum = lagSum + lagTab[stb.lane][2'(j - i - 1)] * errQ[i];
    errNext = dq[stb.lane] - firAcc[stb.lane] - muA * lagSum;
    updSum = '0;
    for (int q = 0; q < 4; q++) updSum = updSum + errQ[q] * tapX(4 - q + k);
    coefNext = coef[tapSel] + muA * updSum;
    errOut   = satW(errQ[stb.lane]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wp  <= '0;
      muA <= '0;
      for (int i = 0; i < BUF_D; i++) xBuf[i] <= '0;
      for (int i = 0; i < TAPS; i++) coef[i] <= '0;
      for (int i = 0; i < 4; i++) begin
        dq[i]     <= '0;
        firAcc[i] <= '0;
        errQ[i]   <= '0;
        for (int p = 0; p < 3; p++) lagTab[i][p] <= '0;
      end
      for (int p = 0; p < 3; p++) corrR[p] <= '0;
    end else begin
      if (stb.take) begin
        xBuf[wp]      <= xIn;
        wp            <= wp + 1'b1;
        dq[stb.lane]  <= acc_t'(dIn);
      end
      if (stb.startBlk) begin
        muA <= acc_t'(muIn);
        for (int q = 0; q < 4; q++) firAcc[q] <= '0;
        if (stb.frameInit) for (int p = 0; p < 3; p++) corrR[p] <= '0;
      end
      if (stb.firStep) begin
        for (int q = 0; q < 4; q++) firAcc[q] <= firAcc[q] + firProd[q];
        if (stb.frameInit)
          for (int p = 0; p < 3; p++) corrR[p] <= corrR[p] + initProd[p];
      end
      if (stb.recurStep)
        for (int p = 0; p < 3; p++) begin
          corrR[p]             <= corrNext[p];
          lagTab[stb.lane][p]  <= corrNext[p];
        end
      if (stb.corrStep) errQ[stb.lane] <= errNext;
      if (stb.updStep)  coef[tapSel]   <= coefNext;
    end
  end

  // R1: every accepted pair advances the history pointer by one slot
  a_r1_ptr_step: assert property (@(posedge clk) disable iff (!rstN)
    stb.take |=> wp == PTR_W'($past(wp) + 1'b1));

  // R4: the latched step size only moves on a block's first pair
  a_r4_mu_held: assert property (@(posedge clk) disable iff (!rstN)
    !stb.startBlk |=> $stable(muA));

endmodule

// File: rtl/block_exact_lms.sv
module block_exact_lms
  import belms_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ACC_W     = 48,
  parameter int MU_W      = 8,
  parameter int TAPS      = 16,
  parameter int FRAME_LEN = 40
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  output logic                     inReady,
  input  logic signed [DATA_W-1:0] xIn,
  input  logic signed [DATA_W-1:0] dIn,
  input  logic [MU_W-1:0]          mu,
  output logic                     outValid,
  input  logic                     outReady,
  output logic signed [DATA_W-1:0] errOut
);
  belms_strobe_t         stb;
  logic [$clog2(TAPS):0] tapIdx;

  belms_ctrl #(.TAPS(TAPS), .FRAME_LEN(FRAME_LEN)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .outReady(outReady), .outValid(outValid), .stb(stb), .tapIdx(tapIdx)
  );

  belms_datapath #(.DATA_W(DATA_W), .ACC_W(ACC_W), .MU_W(MU_W), .TAPS(TAPS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .tapIdx(tapIdx),
    .xIn(xIn), .dIn(dIn), .muIn(mu), .errOut(errOut)
  );

  // R6: a stalled error stays presented and unchanged
  a_r6_err_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(errOut)));

  // R1: input and output sides never open together
  a_r1_sides_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> !outValid);

endmodule

// File: tb/block_exact_lms_tb.sv
module block_exact_lms_tb;
  localparam int DATA_W = 16;
  localparam int ACC_W  = 48;
  localparam int TAPS   = 16;
  localparam int SHIFT  = 64 - ACC_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic outReady = 1'b0;
  logic signed [DATA_W-1:0] xIn = '0;
  logic signed [DATA_W-1:0] dIn = '0;
  logic [7:0] mu = '0;
  logic inReady, outValid;
  logic signed [DATA_W-1:0] errOut;

  int checks = 0;
  int fails  = 0;
  bit bpOn   = 1'b0;

  longint hr [TAPS];
  longint xr [TAPS];

  always #2 clk = ~clk;

  block_exact_lms #(.DATA_W(DATA_W), .ACC_W(ACC_W), .MU_W(8), .TAPS(TAPS), .FRAME_LEN(40)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .xIn(xIn), .dIn(dIn), .mu(mu), .outValid(outValid),
    .outReady(outReady), .errOut(errOut)
  );

  function automatic longint wrapA(input longint v);
    return (v <<< SHIFT) >>> SHIFT;
  endfunction

  function automatic longint satD(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint refStep(input longint x, input longint d, input longint m);
    longint y, e, me;
    for (int k = TAPS - 1; k > 0; k--) xr[k] = xr[k-1];
    xr[0] = x;
    y = 0;
    for (int k = 0; k < TAPS; k++) y = wrapA(y + hr[k] * xr[k]);
    e  = wrapA(d - y);
    me = wrapA(m * e);
    for (int k = 0; k < TAPS; k++) hr[k] = wrapA(hr[k] + me * xr[k]);
    return e;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    outReady = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < TAPS; k++) begin hr[k] = 0; xr[k] = 0; end
    @(negedge clk);
    check("R5 inReady after reset", longint'(inReady), 1);
    check("R5 outValid after reset", longint'(outValid), 0);
  endtask

  task automatic putSample(input longint x, input longint d, input int m);
    int gap;
    gap = $urandom_range(0, 2);
    repeat (gap) @(negedge clk);
    inValid = 1'b1;
    xIn = DATA_W'(x);
    dIn = DATA_W'(d);
    mu  = 8'(m);
    if (!inReady) begin
      fails++;
      $display("FAIL R1: inReady actual 0 expected 1 while gathering");
    end
    @(posedge clk);
    #1;
    inValid = 1'b0;
  endtask

  task automatic runBlock(input string tag, input longint xs[4], input longint ds[4], input int ms[4]);
    longint expv [4];
    int lat, idx;
    bit take, seen;
    for (int j = 0; j < 4; j++) expv[j] = satD(refStep(xs[j], ds[j], longint'(ms[0])));
    for (int j = 0; j < 4; j++) putSample(xs[j], ds[j], ms[j]);
    mu = 8'($urandom_range(0, 255));
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (outValid == 1'b0 && inReady == 1'b1) begin
        fails++;
        $display("FAIL R1: inReady actual 1 expected 0 while busy");
      end
    end while (!outValid && lat < 2000);
    check("R9 latency", longint'(lat - 1), longint'(2 * TAPS + 8));
    idx = 0;
    seen = 1'b0;
    while (idx < 4) begin
      if (!outValid) begin
        check("R6 outValid held", 0, 1);
        break;
      end
      if (expv[idx] == 32767 || expv[idx] == -32768)
        check("R3 saturated error", longint'(errOut), expv[idx]);
      else if (seen)
        check("R6 stalled error", longint'(errOut), expv[idx]);
      else
        check(tag, longint'(errOut), expv[idx]);
      take = bpOn ? ($urandom_range(0, 2) != 0) : 1'b1;
      outReady = take;
      @(negedge clk);
      outReady = 1'b0;
      if (take) begin idx++; seen = 1'b0; end
      else seen = 1'b1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    longint xs[4], ds[4];
    int ms[4];
    void'($urandom(32'd4242));
    doReset();

    // R7 / R5: zero step from reset, weights stay zero so e equals d
    for (int b = 0; b < 2; b++) begin
      for (int j = 0; j < 4; j++) begin
        xs[j] = longint'($urandom_range(0, 8)) - 4;
        ds[j] = longint'($urandom_range(0, 40)) - 20;
        ms[j] = 0;
      end
      runBlock("R7 zero step", xs, ds, ms);
    end

    // R2: small directed adaptation
    for (int b = 0; b < 4; b++) begin
      for (int j = 0; j < 4; j++) begin
        xs[j] = longint'($urandom_range(0, 6)) - 3;
        ds[j] = longint'($urandom_range(0, 30)) - 15;
        ms[j] = 1;
      end
      runBlock("R2 exact LMS", xs, ds, ms);
    end

    // R4: step size altered inside the block must be ignored
    bpOn = 1'b1;
    for (int j = 0; j < 4; j++) begin
      xs[j] = longint'($urandom_range(0, 6)) - 3;
      ds[j] = longint'($urandom_range(0, 30)) - 15;
    end
    ms[0] = 1; ms[1] = 3; ms[2] = 0; ms[3] = 2;
    runBlock("R4 mu latch", xs, ds, ms);

    // R7: frozen weights after adaptation
    for (int b = 0; b < 2; b++) begin
      for (int j = 0; j < 4; j++) begin
        xs[j] = longint'($urandom_range(0, 6)) - 3;
        ds[j] = longint'($urandom_range(0, 30)) - 15;
        ms[j] = 0;
      end
      runBlock("R7 frozen weights", xs, ds, ms);
    end

    // R3: forced saturation after a mid-run reset
    doReset();
    xs[0] = 32767; ds[0] = 32767;
    xs[1] = 32767; ds[1] = -32768;
    xs[2] = -32768; ds[2] = 32767;
    xs[3] = 1; ds[3] = 0;
    ms[0] = 1; ms[1] = 1; ms[2] = 1; ms[3] = 1;
    runBlock("R3 clamp", xs, ds, ms);

    // R8: random full-range blocks over several frames
    for (int b = 0; b < 32; b++) begin
      for (int j = 0; j < 4; j++) begin
        xs[j] = longint'($urandom_range(0, 65535)) - 32768;
        ds[j] = longint'($urandom_range(0, 65535)) - 32768;
        ms[j] = int'($urandom_range(0, 3));
      end
      runBlock("R8 across frames", xs, ds, ms);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule